// File: doc/BRIEF.md
# Counted-Burst I2C Target Read Sequencer

This block serves the read half of an I2C target. A bus front end, which is not part of the block, recovers the bus events and passes them in as single-cycle strobes. These events are an address match with its direction bit, a per-bit advance at each SCL falling edge, the master's acknowledge result, STOP and repeated START. A host fills a byte buffer, writes a burst length and controls the acknowledge-enable bit (AA) and the interrupt flag (SI).

Once the block has been addressed for a read, it shifts out a whole counted burst of buffer bytes before it interrupts the host again. The interrupt is reported with an 8-bit status code. While the flag is set, the block asks the front end to stretch SCL, so the host has time to refill the buffer and the length between bursts.

The block can also become a target transmitter after a master engine loses arbitration. If the host clears AA in the middle of a burst, the block still sends the rest of that burst. It then detaches from the bus and leaves SDA released, so a master that keeps reading sees only ones.

Top module: `i2cst_burst_tx`

## Requirements
- R1: After reset the status is F8h, `int_n` is 1, `scl_hold` is 0 and `sda_out` is 1 (released).
- R2: In the idle state, an address strobe with `addr_rw`=1 while `host_aa`=1 sets status A8h, drives `int_n` low and raises `scl_hold` on the next cycle. An address strobe with `addr_rw`=0 has no effect.
- R3: If `arb_lost` pulsed at any time since the block was last addressed, the next read addressing reports B0h instead of A8h.
- R4: After the host pulses `si_clr`, buffer entry 0 appears on `sda_out` MSB first. Each `bit_adv` strobe moves to the next bit, and after eight advances `sda_out` is 1 for the acknowledge slot.
- R5: A burst carries `host_count` bytes, taken from buffer entries 0, 1, 2 and on. The next entry is loaded only when the acknowledge for the previous byte arrives. A count of 0 is treated as 1.
- R6: An ACK (`ack_nack`=0) on the last counted byte while `host_aa`=1 gives status B8h with the interrupt set. The next `si_clr` starts a new burst from entry 0 with a freshly sampled count.
- R7: A NACK (`ack_nack`=1) on any byte ends the burst with status C0h and the interrupt set, even when fewer bytes than the count were sent.
- R8: When `host_aa` is 0 at the ACK of the last byte, the status becomes C8h, and the bytes left in the burst are still sent after AA is cleared.
- R9: After C0h or C8h has been cleared, the block is detached: `sda_out` stays 1 whatever `bit_adv` strobes arrive.
- R10: A STOP or repeated START while detached or while sending gives status F8h with no interrupt.
- R11: While `host_aa` is 0 in the idle state, read address strobes are ignored. Setting `host_aa` back to 1 lets the next one be recognised.
- R12: While the interrupt is set, `scl_hold` is 1 and the status holds until `si_clr`; bus strobes have no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hit | input | 1 | Own-address match strobe |
| addr_rw | input | 1 | Direction bit of the match, 1 = read |
| bit_adv | input | 1 | Advance to the next data bit (SCL falling edge) |
| ack_stb | input | 1 | Master acknowledge sampled |
| ack_nack | input | 1 | Acknowledge value, 1 = NACK |
| stop_det | input | 1 | STOP detected |
| rstart_det | input | 1 | Repeated START detected |
| arb_lost | input | 1 | Arbitration-lost pulse from the master engine |
| host_aa | input | 1 | Acknowledge enable |
| host_count | input | CNT_W | Burst length |
| si_clr | input | 1 | Host clears the interrupt flag |
| buf_we | input | 1 | Buffer write enable |
| buf_waddr | input | CNT_W | Buffer write address |
| buf_wdata | input | DW | Buffer write data |
| status | output | 8 | Status code |
| int_n | output | 1 | Interrupt, active low |
| scl_hold | output | 1 | Request to stretch SCL |
| sda_out | output | 1 | Serial data, 1 = released |

## Verification
The assertions check on every cycle the status codes and interrupt that follow addressing, NACK and bus-end events, and that SDA stays released outside a send. They also check that the status and the clock hold are frozen while the interrupt waits for the host. Only the bench scenarios can show that the byte values come out in buffer order and MSB first, that the length (including zero) is honoured, and that a burst started with AA cleared midway still completes. The same holds for the restart from entry 0 after B8h and for the arbitration history that selects B0h.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SEND,
    ST_SEND,
    ST_WAIT_DET,
    ST_DETACH
  } seq_state_t;

  localparam logic [7:0] STS_ADDR_RD  = 8'hA8;
  localparam logic [7:0] STS_ARB_RD   = 8'hB0;
  localparam logic [7:0] STS_BURST_OK = 8'hB8;
  localparam logic [7:0] STS_NACKED   = 8'hC0;
  localparam logic [7:0] STS_LAST_DET = 8'hC8;
  localparam logic [7:0] STS_IDLE     = 8'hF8;
endpackage

// File: rtl/i2cst_rst_sync.sv
module i2cst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/i2cst_buf.sv
module i2cst_buf #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/i2cst_shift.sv
module i2cst_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          adv,
  output logic          msb,
  output logic          done
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = load_data;
      cnt_d = '0;
    end else if (adv && (cnt_q != FULL)) begin
      sh_d  = {sh_q[DW-2:0], 1'b0};
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= FULL;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb  = sh_q[DW-1];
  assign done = (cnt_q == FULL);
endmodule

// File: rtl/i2cst_seq.sv
module i2cst_seq
  import i2cst_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_hit,
  input  logic             addr_rw,
  input  logic             ack_stb,
  input  logic             ack_nack,
  input  logic             stop_det,
  input  logic             rstart_det,
  input  logic             arb_lost,
  input  logic             host_aa,
  input  logic [CNT_W-1:0] host_count,
  input  logic             si_clr,
  input  logic             byte_done,
  output seq_state_t       state,
  output logic [7:0]       status,
  output logic             si,
  output logic             load,
  output logic [CNT_W-1:0] rd_idx,
  output logic             arb_flag
);
  seq_state_t       state_q, state_d;
  logic [7:0]       status_q, status_d;
  logic             si_q, si_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             arb_q, arb_d;
  logic             bus_end, arb_any;

  assign bus_end = stop_det | rstart_det;
  assign arb_any = arb_q | arb_lost;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    si_d     = si_q;
    remain_d = remain_q;
    idx_d    = idx_q;
    arb_d    = arb_any;
    load     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (addr_hit && addr_rw && host_aa) begin
          status_d = arb_any ? STS_ARB_RD : STS_ADDR_RD;
          si_d     = 1'b1;
          arb_d    = 1'b0;
          state_d  = ST_WAIT_SEND;
        end
      end
      ST_WAIT_SEND: begin
        if (si_clr) begin
          si_d     = 1'b0;
          remain_d = (host_count == '0) ? CNT_W'(1) : host_count;
          idx_d    = '0;
          load     = 1'b1;
          state_d  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (bus_end) begin
          status_d = STS_IDLE;
          state_d  = ST_IDLE;
        end else if (ack_stb && byte_done) begin
          if (ack_nack) begin
            status_d = STS_NACKED;
            si_d     = 1'b1;
            state_d  = ST_WAIT_DET;
          end else if (remain_q == CNT_W'(1)) begin
            si_d = 1'b1;
            if (host_aa) begin
              status_d = STS_BURST_OK;
              state_d  = ST_WAIT_SEND;
            end else begin
              status_d = STS_LAST_DET;
              state_d  = ST_WAIT_DET;
            end
          end else begin
            remain_d = remain_q - CNT_W'(1);
            idx_d    = idx_q + CNT_W'(1);
            load     = 1'b1;
          end
        end
      end
      ST_WAIT_DET: begin
        if (si_clr) begin
          si_d    = 1'b0;
          state_d = ST_DETACH;
        end
      end
      ST_DETACH: begin
        if (bus_end) begin
          status_d = STS_IDLE;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      status_q <= STS_IDLE;
      si_q     <= 1'b0;
      remain_q <= '0;
      idx_q    <= '0;
      arb_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      si_q     <= si_d;
      remain_q <= remain_d;
      idx_q    <= idx_d;
      arb_q    <= arb_d;
    end
  end

  assign rd_idx   = (state_q == ST_SEND) ? (idx_q + CNT_W'(1)) : '0;
  assign state    = state_q;
  assign status   = status_q;
  assign si       = si_q;
  assign arb_flag = arb_q;
endmodule

// File: rtl/i2cst_burst_tx.sv
module i2cst_burst_tx
  import i2cst_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_hit,
  input  logic             addr_rw,
  input  logic             bit_adv,
  input  logic             ack_stb,
  input  logic             ack_nack,
  input  logic             stop_det,
  input  logic             rstart_det,
  input  logic             arb_lost,
  input  logic             host_aa,
  input  logic [CNT_W-1:0] host_count,
  input  logic             si_clr,
  input  logic             buf_we,
  input  logic [CNT_W-1:0] buf_waddr,
  input  logic [DW-1:0]    buf_wdata,
  output logic [7:0]       status,
  output logic             int_n,
  output logic             scl_hold,
  output logic             sda_out
);
  logic             rst_sync_n;
  seq_state_t       seq_state;
  logic             si, load, arb_flag, byte_done, sh_msb;
  logic [CNT_W-1:0] rd_idx;
  logic [DW-1:0]    rd_data;
  logic             sending;

  i2cst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  i2cst_buf #(.DW(DW), .AW(CNT_W)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_addr (buf_waddr),
    .wr_data (buf_wdata),
    .rd_addr (rd_idx),
    .rd_data (rd_data)
  );

  assign sending = (seq_state == ST_SEND);

  i2cst_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .load_data (rd_data),
    .adv       (bit_adv && sending),
    .msb       (sh_msb),
    .done      (byte_done)
  );

  i2cst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_hit   (addr_hit),
    .addr_rw    (addr_rw),
    .ack_stb    (ack_stb),
    .ack_nack   (ack_nack),
    .stop_det   (stop_det),
    .rstart_det (rstart_det),
    .arb_lost   (arb_lost),
    .host_aa    (host_aa),
    .host_count (host_count),
    .si_clr     (si_clr),
    .byte_done  (byte_done),
    .state      (seq_state),
    .status     (status),
    .si         (si),
    .load       (load),
    .rd_idx     (rd_idx),
    .arb_flag   (arb_flag)
  );

  assign int_n    = ~si;
  assign scl_hold = si;
  assign sda_out  = (sending && !byte_done) ? sh_msb : 1'b1;
endmodule

// File: rtl/i2cst_burst_tx_chk.sv
module i2cst_burst_tx_chk
  import i2cst_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input seq_state_t st,
  input logic       addr_hit,
  input logic       addr_rw,
  input logic       host_aa,
  input logic       arb_q,
  input logic       arb_lost,
  input logic       ack_stb,
  input logic       ack_nack,
  input logic       byte_done,
  input logic       stop_det,
  input logic       rstart_det,
  input logic       si_clr,
  input logic [7:0] status,
  input logic       int_n,
  input logic       scl_hold,
  input logic       sda_out
);
  assert_addr_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && addr_hit && addr_rw && host_aa && !arb_q && !arb_lost)
      |=> (status == 8'hA8 && !int_n && scl_hold));

  assert_arb_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && addr_hit && addr_rw && host_aa && arb_q)
      |=> (status == 8'hB0));

  assert_nack_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND && ack_stb && byte_done && ack_nack && !stop_det && !rstart_det)
      |=> (status == 8'hC0 && !int_n));

  assert_detached_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DETACH) |-> sda_out);

  assert_bus_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DETACH && (stop_det || rstart_det)) |=> (status == 8'hF8 && int_n));

  assert_aa_off_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !host_aa) |=> int_n);

  assert_int_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !si_clr) |=> ($stable(status) && !int_n && scl_hold));
endmodule

bind i2cst_burst_tx i2cst_burst_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .st         (seq_state),
  .addr_hit   (addr_hit),
  .addr_rw    (addr_rw),
  .host_aa    (host_aa),
  .arb_q      (arb_flag),
  .arb_lost   (arb_lost),
  .ack_stb    (ack_stb),
  .ack_nack   (ack_nack),
  .byte_done  (byte_done),
  .stop_det   (stop_det),
  .rstart_det (rstart_det),
  .si_clr     (si_clr),
  .status     (status),
  .int_n      (int_n),
  .scl_hold   (scl_hold),
  .sda_out    (sda_out)
);

// File: tb/i2cst_burst_tx_tb.sv
module i2cst_burst_tx_tb;
  localparam int CNT_W = 7;
  localparam int DW    = 8;

  logic clk, rst_n;
  logic addr_hit, addr_rw, bit_adv, ack_stb, ack_nack, stop_det, rstart_det;
  logic arb_lost, host_aa, si_clr, buf_we;
  logic [CNT_W-1:0] host_count, buf_waddr;
  logic [DW-1:0] buf_wdata;
  logic [7:0] status;
  logic int_n, scl_hold, sda_out;

  int n_run, n_fail;
  bit done_flag;
  logic [7:0] mirror [16];

  i2cst_burst_tx #(.CNT_W(CNT_W), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .addr_rw(addr_rw),
    .bit_adv(bit_adv), .ack_stb(ack_stb), .ack_nack(ack_nack),
    .stop_det(stop_det), .rstart_det(rstart_det), .arb_lost(arb_lost),
    .host_aa(host_aa), .host_count(host_count), .si_clr(si_clr),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .status(status), .int_n(int_n), .scl_hold(scl_hold), .sda_out(sda_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_addr_sts(bit arb);
    return arb ? 8'hB0 : 8'hA8;
  endfunction

  function automatic logic [7:0] exp_end_sts(bit aa);
    return aa ? 8'hB8 : 8'hC8;
  endfunction

  function automatic int exp_len(int cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic addr(bit rw);
    addr_hit = 1'b1; addr_rw = rw;
    @(negedge clk);
    addr_hit = 1'b0; addr_rw = 1'b0;
  endtask

  task automatic adv();
    bit_adv = 1'b1;
    @(negedge clk);
    bit_adv = 1'b0;
  endtask

  task automatic ack(bit nack);
    ack_stb = 1'b1; ack_nack = nack;
    @(negedge clk);
    ack_stb = 1'b0; ack_nack = 1'b0;
  endtask

  task automatic release_si(int cnt);
    host_count = CNT_W'(cnt); si_clr = 1'b1;
    @(negedge clk);
    si_clr = 1'b0;
  endtask

  task automatic bus_end(bit rs);
    if (rs) rstart_det = 1'b1; else stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0; rstart_det = 1'b0;
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) begin
      mirror[i] = 8'($urandom);
      buf_we = 1'b1; buf_waddr = CNT_W'(i); buf_wdata = mirror[i];
      @(negedge clk);
    end
    buf_we = 1'b0;
  endtask

  task automatic read_byte(logic [7:0] exp, string req);
    logic [7:0] v = '0;
    for (int b = 0; b < 8; b++) begin
      v = {v[6:0], sda_out};
      adv();
    end
    chk({req, " byte"}, v, exp);
    chk("R4 ack slot released", sda_out, 1);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done_flag = 1'b0;
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    addr_hit = 0; addr_rw = 0; bit_adv = 0; ack_stb = 0; ack_nack = 0;
    stop_det = 0; rstart_det = 0; arb_lost = 0; host_aa = 1; si_clr = 0;
    buf_we = 0; host_count = '0; buf_waddr = '0; buf_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", status, 8'hF8);
    chk("R1 int_n", int_n, 1);
    chk("R1 scl_hold", scl_hold, 0);
    chk("R1 sda_out", sda_out, 1);

    fill(16);

    // R2 write-direction address ignored
    addr(1'b0);
    chk("R2 write dir int_n", int_n, 1);
    chk("R2 write dir status", status, 8'hF8);

    // R11 AA off ignores read address
    host_aa = 1'b0;
    addr(1'b1);
    chk("R11 aa off int_n", int_n, 1);
    chk("R11 aa off status", status, 8'hF8);
    host_aa = 1'b1;

    // R2 / R11 read address recognised again
    addr(1'b1);
    chk("R2 status", status, exp_addr_sts(0));
    chk("R2 int_n", int_n, 0);
    chk("R2 scl_hold", scl_hold, 1);

    // R12 bus strobes ignored while SI set
    bus_end(1'b0);
    adv();
    chk("R12 status held", status, 8'hA8);
    chk("R12 int_n held", int_n, 0);

    // R4 R5 R6 three-byte burst
    release_si(3);
    chk("R6 int released", int_n, 1);
    for (int k = 0; k < 3; k++) begin
      read_byte(mirror[k], "R4 R5 burst3");
      ack(1'b0);
    end
    chk("R6 status", status, exp_end_sts(1));
    chk("R6 int_n", int_n, 0);

    // R5 count zero sends one byte, R6 restarts at entry 0
    fill(16);
    release_si(0);
    for (int k = 0; k < exp_len(0); k++) begin
      read_byte(mirror[k], "R5 zero count");
      ack(1'b0);
    end
    chk("R5 zero count status", status, 8'hB8);

    // random bursts
    for (int r = 0; r < 6; r++) begin
      int cnt;
      cnt = 1 + int'($urandom_range(0, 9));
      fill(16);
      release_si(cnt);
      for (int k = 0; k < exp_len(cnt); k++) begin
        read_byte(mirror[k], "R5 random burst");
        ack(1'b0);
      end
      chk("R6 random status", status, exp_end_sts(1));
      chk("R12 random hold", scl_hold, 1);
    end

    // R7 NACK on second of five
    release_si(5);
    read_byte(mirror[0], "R7 pre-nack");
    ack(1'b0);
    read_byte(mirror[1], "R7 nacked");
    ack(1'b1);
    chk("R7 status", status, 8'hC0);
    chk("R7 int_n", int_n, 0);
    release_si(5);
    // R9 detached drives ones
    for (int b = 0; b < 9; b++) begin
      chk("R9 detached sda", sda_out, 1);
      adv();
    end
    chk("R9 still no int", int_n, 1);
    bus_end(1'b0);
    chk("R10 stop status", status, 8'hF8);
    chk("R10 stop int_n", int_n, 1);

    // R3 arbitration lost, then R8 AA cleared midway
    arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
    repeat (2) @(negedge clk);
    addr(1'b1);
    chk("R3 status", status, exp_addr_sts(1));
    fill(16);
    release_si(3);
    for (int k = 0; k < 3; k++) begin
      read_byte(mirror[k], "R8 aa cleared burst");
      if (k == 0) host_aa = 1'b0;
      ack(1'b0);
      if (k < 2) chk("R8 no early int", int_n, 1);
    end
    chk("R8 status", status, exp_end_sts(0));
    chk("R8 int_n", int_n, 0);
    release_si(3);
    for (int b = 0; b < 9; b++) begin
      chk("R9 after C8 sda", sda_out, 1);
      adv();
    end
    bus_end(1'b1);
    chk("R10 rstart status", status, 8'hF8);

    // R11 idle with AA off, then resume
    addr(1'b1);
    chk("R11 still off", int_n, 1);
    host_aa = 1'b1;
    addr(1'b1);
    chk("R11 resumed status", status, exp_addr_sts(0));

    // R10 STOP during sending
    release_si(4);
    read_byte(mirror[0], "R10 pre-stop");
    bus_end(1'b0);
    chk("R10 stop mid-burst status", status, 8'hF8);
    chk("R10 stop mid-burst sda", sda_out, 1);

    finish_run();
  end
endmodule